// File: doc/BRIEF.md
# Memory Test Command Generator

This block produces an endless stream of memory commands for exercising a memory controller under test. Each command carries a target address, a burst length and a write/read flag, and is offered on a valid/ready interface. The controller consumes a command by raising ready while valid is high, and the generator then presents the next one.

Three modes can be changed at runtime: the address mode (fixed, pseudo-random or sequential), the burst-length mode (fixed or pseudo-random) and the instruction mode (writes only, reads only or alternating). They are loaded from a small configuration port only when its enable qualifier is high. A pseudo-random burst length forces the address to be pseudo-random as well. A 32-bit LFSR supplies the pseudo-random fields. A running counter supplies sequential addresses. A build-time eye-test switch turns the block into a write-only generator aimed at one fixed location, whatever instruction mode is configured.

Top module: `memtest_cmd_gen`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, cmd_valid is 0. The first command is presented on the first clock edge after reset is released. From then on cmd_valid stays 1.
- R2: While cmd_valid is 1 and cmd_ready is 0, cmd_addr, cmd_bl and cmd_write hold their values.
- R3: Address mode codes are 1 = fixed (FIXED_ADDR), 2 = pseudo-random (LFSR bits [ADDR_W-1:0]) and 3 = sequential. The mode after reset is 3.
- R4: A sequential command uses the running address. The running address then advances by that command's burst length, and returns to 0 when the sum reaches ADDR_LIMIT. It starts at 0 after reset.
- R5: Burst-length mode codes are 1 = fixed (FIXED_BL) and 2 = pseudo-random, computed as LFSR bits [31:32-BL_LOG] plus 1, so the value always lies between 1 and 2**BL_LOG. The mode after reset is 1.
- R6: When the burst-length mode is 2, the address is pseudo-random whatever the configured address mode.
- R7: The LFSR is loaded with LFSR_SEED at reset. It steps once for each generated command, as a right-shifting Galois register with feedback mask 32'h80200003. Each command uses the LFSR value from before that step.
- R8: Configuration codes are taken only on a generation cycle (cmd_valid low, or cmd_ready high) with cfg_modify_en at 1. New modes already apply to the command generated in that cycle. At any other time the configuration inputs have no effect.
- R9: Illegal codes (address mode 0, burst-length mode 0 or 3, instruction mode 0) leave that mode unchanged, while legal codes in the same update are still taken.
- R10: Instruction mode codes are 1 = write only, 2 = read only and 3 = alternate (the mode after reset). In alternate mode a command is a write when an even number of commands has been generated since reset (cmd_write = 1 means write).
- R11: With EYE_TEST = 1, every command is a write to FIXED_ADDR and the instruction mode is ignored. The burst length still follows the burst-length mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_modify_en | input | 1 | Qualifier that allows the mode codes to be loaded |
| cfg_addr_mode | input | 2 | Requested address mode code |
| cfg_bl_mode | input | 2 | Requested burst-length mode code |
| cfg_instr_mode | input | 2 | Requested instruction mode code |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_addr | output | ADDR_W | Command address |
| cmd_bl | output | BL_LOG+1 | Command burst length |
| cmd_write | output | 1 | 1 = write, 0 = read |

## Verification
The assertions assume that cmd_ready and the configuration inputs are free of X and change only between clock edges. They also assume a consumer may hold ready low for any number of cycles without that being an error. The stimulus drives every input at the falling clock edge. It pulses cfg_modify_en for single cycles, some of them deliberately placed inside stalls and some carrying illegal codes. Ready-low gaps are inserted in a fixed, repeating pattern, so the hold and mode-latching rules are exercised under back-pressure.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd1,
        AM_PRBS  = 2'd2,
        AM_SEQ   = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        BM_FIXED = 2'd1,
        BM_PRBS  = 2'd2
    } bl_mode_e;

    typedef enum logic [1:0] {
        IM_WRITE = 2'd1,
        IM_READ  = 2'd2,
        IM_ALT   = 2'd3
    } instr_mode_e;

    localparam int          LFSR_W    = 32;
    localparam logic [31:0] LFSR_MASK = 32'h80200003;

endpackage

// File: rtl/mtg_mode_filter.sv
module mtg_mode_filter
    import memtest_pkg::*;
(
    input  logic        load,
    input  logic        modify_en,
    input  logic [1:0]  req_addr,
    input  logic [1:0]  req_bl,
    input  logic [1:0]  req_instr,
    input  addr_mode_e  cur_am,
    input  bl_mode_e    cur_bm,
    input  instr_mode_e cur_im,
    output addr_mode_e  nxt_am,
    output bl_mode_e    nxt_bm,
    output instr_mode_e nxt_im
);

    logic take;

    always_comb begin
        take   = load && modify_en;
        nxt_am = cur_am;
        nxt_bm = cur_bm;
        nxt_im = cur_im;
        if (take) begin
            // R9: each field is filtered on its own
            if (req_addr != 2'd0)                        nxt_am = addr_mode_e'(req_addr);
            if (req_bl == 2'd1 || req_bl == 2'd2)        nxt_bm = bl_mode_e'(req_bl);
            if (req_instr != 2'd0)                       nxt_im = instr_mode_e'(req_instr);
        end
    end

endmodule

// File: rtl/mtg_lfsr_step.sv
module mtg_lfsr_step #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    always_comb begin
        nxt = cur >> 1;
        if (cur[0]) nxt = nxt ^ MASK;
    end

endmodule

// File: rtl/mtg_addr_unit.sv
module mtg_addr_unit
    import memtest_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                BL_W       = 4,
    parameter int                ADDR_LIMIT = 4096,
    parameter logic [ADDR_W-1:0] FIXED_ADDR = '0
) (
    input  addr_mode_e        mode,
    input  logic [ADDR_W-1:0] rnd,
    input  logic [ADDR_W-1:0] seq_cur,
    input  logic [BL_W-1:0]   bl,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] seq_nxt
);

    localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(ADDR_LIMIT);

    logic [ADDR_W:0] sum;

    always_comb begin
        sum     = {1'b0, seq_cur} + (ADDR_W+1)'(bl);
        seq_nxt = seq_cur;
        unique case (mode)
            AM_FIXED: addr = FIXED_ADDR;
            AM_PRBS:  addr = rnd;
            default: begin
                addr    = seq_cur;
                seq_nxt = (sum >= LIM) ? '0 : sum[ADDR_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/memtest_cmd_gen.sv
module memtest_cmd_gen
    import memtest_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                BL_LOG     = 3,
    parameter int                ADDR_LIMIT = 4096,
    parameter logic [ADDR_W-1:0] FIXED_ADDR = 16'h0123,
    parameter int                FIXED_BL   = 4,
    parameter logic [31:0]       LFSR_SEED  = 32'h1D2C3B4A,
    parameter bit                EYE_TEST   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_modify_en,
    input  logic [1:0]        cfg_addr_mode,
    input  logic [1:0]        cfg_bl_mode,
    input  logic [1:0]        cfg_instr_mode,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BL_LOG:0]   cmd_bl,
    output logic              cmd_write
);

    localparam int BL_W = BL_LOG + 1;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [BL_W-1:0]   bl;
        logic              write;
        logic [LFSR_W-1:0] lfsr;
        logic [ADDR_W-1:0] seq;
        logic              phase;
        addr_mode_e        am;
        bl_mode_e          bm;
        instr_mode_e       im;
    } state_t;

    state_t st_q, st_d;

    logic              gen;
    addr_mode_e        am_n, eff_am;
    bl_mode_e          bm_n;
    instr_mode_e       im_n;
    logic [LFSR_W-1:0] lfsr_n;
    logic [BL_W-1:0]   bl_new;
    logic [ADDR_W-1:0] addr_new, seq_new;

    assign gen = !st_q.valid || cmd_ready;

    mtg_mode_filter u_mode (
        .load      (gen),
        .modify_en (cfg_modify_en),
        .req_addr  (cfg_addr_mode),
        .req_bl    (cfg_bl_mode),
        .req_instr (cfg_instr_mode),
        .cur_am    (st_q.am),
        .cur_bm    (st_q.bm),
        .cur_im    (st_q.im),
        .nxt_am    (am_n),
        .nxt_bm    (bm_n),
        .nxt_im    (im_n)
    );

    mtg_lfsr_step #(.W(LFSR_W), .MASK(LFSR_MASK)) u_lfsr (
        .cur (st_q.lfsr),
        .nxt (lfsr_n)
    );

    // R6: a random burst length drags the address into random mode
    assign eff_am = (bm_n == BM_PRBS) ? AM_PRBS : am_n;
    // R5: random length lands in 1 .. 2**BL_LOG
    assign bl_new = (bm_n == BM_PRBS)
                  ? ({1'b0, st_q.lfsr[LFSR_W-1 -: BL_LOG]} + BL_W'(1))
                  : BL_W'(FIXED_BL);

    mtg_addr_unit #(
        .ADDR_W     (ADDR_W),
        .BL_W       (BL_W),
        .ADDR_LIMIT (ADDR_LIMIT),
        .FIXED_ADDR (FIXED_ADDR)
    ) u_addr (
        .mode    (eff_am),
        .rnd     (st_q.lfsr[ADDR_W-1:0]),
        .seq_cur (st_q.seq),
        .bl      (bl_new),
        .addr    (addr_new),
        .seq_nxt (seq_new)
    );

    always_comb begin
        st_d = st_q;
        if (gen) begin
            st_d.valid = 1'b1;
            st_d.am    = am_n;
            st_d.bm    = bm_n;
            st_d.im    = im_n;
            st_d.lfsr  = lfsr_n;
            st_d.phase = !st_q.phase;
            st_d.bl    = bl_new;
            if (EYE_TEST) begin
                // R11: single-location write stream
                st_d.addr  = FIXED_ADDR;
                st_d.write = 1'b1;
            end else begin
                st_d.addr = addr_new;
                st_d.seq  = seq_new;
                unique case (im_n)
                    IM_WRITE: st_d.write = 1'b1;
                    IM_READ:  st_d.write = 1'b0;
                    default:  st_d.write = !st_q.phase;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.lfsr  <= LFSR_SEED;
            st_q.am    <= AM_SEQ;
            st_q.bm    <= BM_FIXED;
            st_q.im    <= IM_ALT;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_valid = st_q.valid;
    assign cmd_addr  = st_q.addr;
    assign cmd_bl    = st_q.bl;
    assign cmd_write = st_q.write;

endmodule

// File: rtl/memtest_cmd_gen_chk.sv
module memtest_cmd_gen_chk #(
    parameter int                ADDR_W     = 16,
    parameter int                BL_LOG     = 3,
    parameter logic [ADDR_W-1:0] FIXED_ADDR = '0,
    parameter bit                EYE_TEST   = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [BL_LOG:0]   cmd_bl,
    input logic              cmd_write
);

    localparam int BL_MAX = 1 << BL_LOG;

    p_first_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> cmd_valid);

    p_stay_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> cmd_valid);

    p_hold_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            ($stable(cmd_addr) && $stable(cmd_bl) && $stable(cmd_write)));

    p_bl_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_bl != '0 && int'(cmd_bl) <= BL_MAX));

    generate
        if (EYE_TEST) begin : g_eye
            p_eye_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_valid |-> (cmd_write && cmd_addr == FIXED_ADDR));
        end
    endgenerate

endmodule

bind memtest_cmd_gen memtest_cmd_gen_chk #(
    .ADDR_W     (ADDR_W),
    .BL_LOG     (BL_LOG),
    .FIXED_ADDR (FIXED_ADDR),
    .EYE_TEST   (EYE_TEST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_bl    (cmd_bl),
    .cmd_write (cmd_write)
);

// File: tb/memtest_cmd_gen_bench.sv
module memtest_cmd_gen_bench;

    localparam int          AW    = 16;
    localparam int          BLOG  = 3;
    localparam int          LIMIT = 64;
    localparam int          FADDR = 16'h0123;
    localparam int          FBL   = 4;
    localparam logic [31:0] SEED  = 32'h1D2C3B4A;
    localparam int          NCYC  = 560;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          men = 1'b0;
    logic [1:0]    am_in = 2'd0, bm_in = 2'd0, im_in = 2'd0;
    logic          rdy = 1'b0;
    logic          v0, w0, v1, w1;
    logic [AW-1:0] a0, a1;
    logic [BLOG:0] b0, b1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    memtest_cmd_gen #(.ADDR_W(AW), .BL_LOG(BLOG), .ADDR_LIMIT(LIMIT),
        .FIXED_ADDR(16'(FADDR)), .FIXED_BL(FBL), .LFSR_SEED(SEED), .EYE_TEST(1'b0))
    u_memtest_cmd_gen (
        .clk(clk), .rst_n(rst_n), .cfg_modify_en(men), .cfg_addr_mode(am_in),
        .cfg_bl_mode(bm_in), .cfg_instr_mode(im_in), .cmd_valid(v0),
        .cmd_ready(rdy), .cmd_addr(a0), .cmd_bl(b0), .cmd_write(w0));

    memtest_cmd_gen #(.ADDR_W(AW), .BL_LOG(BLOG), .ADDR_LIMIT(LIMIT),
        .FIXED_ADDR(16'(FADDR)), .FIXED_BL(FBL), .LFSR_SEED(SEED), .EYE_TEST(1'b1))
    u_memtest_cmd_gen_eye (
        .clk(clk), .rst_n(rst_n), .cfg_modify_en(men), .cfg_addr_mode(am_in),
        .cfg_bl_mode(bm_in), .cfg_instr_mode(im_in), .cmd_valid(v1),
        .cmd_ready(rdy), .cmd_addr(a1), .cmd_bl(b1), .cmd_write(w1));

    // behavioural reference state
    int          m_valid, m_addr, m_bl, m_write, m_seq, m_phase;
    int          m_am, m_bm, m_im, m_eff;
    logic [31:0] m_lfsr;
    bit          m_stalled;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        m_stalled = (m_valid == 1) && !rdy;
        if (m_valid == 0 || rdy) begin
            if (men) begin
                if (am_in != 0) m_am = am_in;
                if (bm_in == 1 || bm_in == 2) m_bm = bm_in;
                if (im_in != 0) m_im = im_in;
            end
            m_eff = (m_bm == 2) ? 2 : m_am;
            m_bl  = (m_bm == 2) ? int'(m_lfsr[31:29]) + 1 : FBL;
            if (m_eff == 1)      m_addr = FADDR;
            else if (m_eff == 2) m_addr = int'(m_lfsr[15:0]);
            else begin
                m_addr = m_seq;
                m_seq  = (m_seq + m_bl >= LIMIT) ? 0 : m_seq + m_bl;
            end
            if (m_im == 1)      m_write = 1;
            else if (m_im == 2) m_write = 0;
            else                m_write = (m_phase == 0) ? 1 : 0;
            m_phase = 1 - m_phase;
            m_lfsr  = m_lfsr[0] ? ((m_lfsr >> 1) ^ 32'h80200003) : (m_lfsr >> 1);
            m_valid = 1;
        end
    endtask

    task automatic drive(input int c);
        int seg = c / 60;
        int k   = c % 60;
        rdy = (c % 7) != 3;
        men = 1'b0;
        am_in = 2'd0; bm_in = 2'd0; im_in = 2'd0;
        case (seg)
            1: if (k == 0) begin men = 1; am_in = 1; end
            2: if (k == 0) begin men = 1; am_in = 2; end
            3: if (k == 0) begin men = 1; am_in = 3; bm_in = 2; end
            4: if (k == 0) begin men = 1; am_in = 3; bm_in = 1; im_in = 1; end
            5: if (k == 0) begin men = 1; im_in = 2; end
            6: if (k == 0) begin men = 1; am_in = 0; bm_in = 3; im_in = 0; end
               else if (k == 20) begin men = 1; am_in = 1; bm_in = 0; im_in = 0; end
            7: begin am_in = 2; bm_in = 2; im_in = 3; end
            8: begin
                if (k < 6) rdy = 1'b0;
                if (k == 3) begin men = 1; am_in = 2; im_in = 1; end
                if (k == 10) begin men = 1; im_in = 3; bm_in = 2; end
            end
            default: ;
        endcase
    endtask

    function automatic string addr_tag(input int seg);
        if (seg == 6) return "R9";
        if (seg == 7 || seg == 8) return "R8";
        if (m_bm == 2) return "R6";
        if (m_eff == 3) return "R4";
        if (m_eff == 2) return "R7";
        return "R3";
    endfunction

    initial begin
        m_valid = 0; m_addr = 0; m_bl = 0; m_write = 0; m_seq = 0; m_phase = 0;
        m_am = 3; m_bm = 1; m_im = 3; m_eff = 3; m_lfsr = SEED; m_stalled = 0;
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", int'(v0), 0);
        chk("R11", "eye valid in reset", int'(v1), 0);
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            drive(c);
            model_step();
            @(negedge clk);
            chk("R1", "valid", int'(v0), m_valid);
            if (m_stalled) begin
                chk("R2", "held addr", int'(a0), m_addr);
                chk("R2", "held bl", int'(b0), m_bl);
                chk("R2", "held write", int'(w0), m_write);
            end else begin
                chk(addr_tag(c / 60), "addr", int'(a0), m_addr);
                chk((m_bm == 2) ? "R7" : "R5", "bl", int'(b0), m_bl);
                chk((c / 60 == 6) ? "R9" : "R10", "write", int'(w0), m_write);
            end
            chk("R11", "eye valid", int'(v1), m_valid);
            chk("R11", "eye addr", int'(a1), FADDR);
            chk("R11", "eye write", int'(w1), 1);
            chk("R11", "eye bl", int'(b1), m_bl);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (NCYC + 2000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule